// File: doc/BRIEF.md
# Vector Predicate Enable Generator

This block turns the contents of the mask vector register into per-element enables for a group of vector execution lanes. Each request names a starting element index; the block returns one enable bit for each of `NLANES` consecutive elements. The enables are held in a register and appear one clock after the request.

The width of the mask field that belongs to each element is not fixed. It depends on the active configuration: the element width (SEW) divided by the register-group multiplier (LMUL). Only the lowest bit of each field is read as the predicate. A per-instruction control bit chooses between predicated execution and plain execution. In plain execution every element below the active vector length is enabled. Elements at or past the vector length are always disabled. The register file, the compare instructions that write masks, and mask logic operations are outside this block.

Top module: `vmask_extract`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every bit of `lane_en` are 0 after that edge.
- R2: A request with `req_valid`=1 at a clock edge gives `out_valid`=1 after that edge, with the enables for that request. A clock edge with `req_valid`=0 gives `out_valid`=0 and `lane_en` all zero.
- R3: `sew_code` s (0..3) means SEW = 8·2^s bits. `lmul_code` l (0..3) means LMUL = 2^l. MLEN = SEW/LMUL. Lane k handles element i = `base_idx`+k. With `use_mask`=1, the predicate of element i is bit i·MLEN of `v0_bits`.
- R4: With `use_mask`=1, only the lowest bit of each element's MLEN-bit field affects the enable. The other bits of the field are ignored.
- R5: Two configurations with the same SEW/LMUL ratio produce the same enables for the same `v0_bits`, `base_idx` and `vl`.
- R6: With `use_mask`=0 and a legal `sew_code`, every element below `vl` is enabled, whatever `v0_bits` holds.
- R7: An element with index i ≥ `vl` has enable 0, whatever `use_mask` and `v0_bits` hold.
- R8: A `sew_code` from 4 to 7 is illegal. The request still gives `out_valid`=1, and every bit of `lane_en` is 0.
- R9: A masked element whose bit position i·MLEN is VLEN or more reads a predicate of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| base_idx | input | IDXW | Index of the element handled by lane 0 |
| vl | input | IDXW | Active vector length |
| sew_code | input | 3 | Element width code (SEW = 8·2^code) |
| lmul_code | input | 2 | Group multiplier code (LMUL = 2^code) |
| use_mask | input | 1 | 1: predicated by `v0_bits`; 0: plain execution |
| v0_bits | input | VLEN | Contents of the mask vector register |
| out_valid | output | 1 | Enables for the previous request are present |
| lane_en | output | NLANES | Per-lane element enables |

## Verification
The assertions assume that requests use a `vl` no larger than the maximum vector length of the chosen configuration. They also assume that `base_idx` plus the lane count does not wrap the index width. The bench respects both assumptions in its randomized phase: it derives `vl` from the configuration and keeps `base_idx` below that maximum. Requests that break these limits appear only in directed cases, where the expected result is stated by a requirement: R9 positions beyond the register, and R8 illegal width codes.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

    localparam int SEW_CODE_W    = 3;
    localparam int LMUL_CODE_W   = 2;
    localparam int MAX_SEW_CODE  = 3;
    localparam int SEW_BASE_LOG2 = 3;
    localparam int SHIFT_W       = 3;

    typedef struct packed {
        logic [SEW_CODE_W-1:0]  sew;
        logic [LMUL_CODE_W-1:0] lmul;
    } vcfg_t;

    typedef struct packed {
        logic               legal;
        logic [SHIFT_W-1:0] shift;
    } vlayout_t;

    function automatic logic cfg_is_legal(vcfg_t c);
        return c.sew <= SEW_CODE_W'(MAX_SEW_CODE);
    endfunction

    // log2(MLEN) = log2(SEW) - log2(LMUL)
    function automatic logic [SHIFT_W-1:0] field_log2(vcfg_t c);
        logic [SHIFT_W:0] sum;
        sum = (SHIFT_W+1)'(SEW_BASE_LOG2) + (SHIFT_W+1)'(c.sew)
            - (SHIFT_W+1)'(c.lmul);
        return sum[SHIFT_W-1:0];
    endfunction

endpackage

// File: rtl/vmask_cfg_decode.sv
module vmask_cfg_decode
    import vmask_pkg::*;
(
    input  vcfg_t    cfg_i,
    output vlayout_t layout_o
);
    always_comb begin
        layout_o.legal = cfg_is_legal(cfg_i);
        layout_o.shift = layout_o.legal ? field_log2(cfg_i) : '0;
    end
endmodule

// File: rtl/vmask_lane.sv
module vmask_lane
    import vmask_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int IDXW = 8
) (
    input  logic [IDXW:0]    idx_i,
    input  logic [IDXW-1:0]  vl_i,
    input  vlayout_t         layout_i,
    input  logic             use_mask_i,
    input  logic [VLEN-1:0]  v0_i,
    output logic             en_o
);
    localparam int VIDX = $clog2(VLEN);
    localparam int PW   = IDXW + 1 + (1 << SHIFT_W);

    logic [PW-1:0] bit_pos;
    logic          pos_inside;
    logic          pred_bit;
    logic          below_vl;

    always_comb begin
        // field start = index * MLEN, MLEN a power of two
        bit_pos    = PW'(idx_i) << layout_i.shift;
        pos_inside = bit_pos < PW'(VLEN);
        pred_bit   = pos_inside ? v0_i[bit_pos[VIDX-1:0]] : 1'b0;
        below_vl   = idx_i < {1'b0, vl_i};
        en_o       = layout_i.legal & below_vl & (~use_mask_i | pred_bit);
    end
endmodule

// File: rtl/vmask_extract.sv
module vmask_extract
    import vmask_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int NLANES = 4,
    parameter int IDXW   = $clog2(VLEN) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [IDXW-1:0]        base_idx,
    input  logic [IDXW-1:0]        vl,
    input  logic [SEW_CODE_W-1:0]  sew_code,
    input  logic [LMUL_CODE_W-1:0] lmul_code,
    input  logic                   use_mask,
    input  logic [VLEN-1:0]        v0_bits,
    output logic                   out_valid,
    output logic [NLANES-1:0]      lane_en
);
    localparam int EXTW = IDXW + 2;

    vcfg_t             cfg;
    vlayout_t          layout;
    logic [NLANES-1:0] en_next;

    assign cfg.sew  = sew_code;
    assign cfg.lmul = lmul_code;

    vmask_cfg_decode u_decode (
        .cfg_i    (cfg),
        .layout_o (layout)
    );

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        logic [IDXW:0] lane_idx;
        assign lane_idx = {1'b0, base_idx} + (IDXW+1)'(k);

        vmask_lane #(
            .VLEN (VLEN),
            .IDXW (IDXW)
        ) u_lane (
            .idx_i      (lane_idx),
            .vl_i       (vl),
            .layout_i   (layout),
            .use_mask_i (use_mask),
            .v0_i       (v0_bits),
            .en_o       (en_next[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            lane_en   <= '0;
        end else begin
            out_valid <= req_valid;
            lane_en   <= req_valid ? en_next : '0;
        end
    end

    // whole lane group lies below vl
    logic group_fits;
    assign group_fits = (EXTW'(base_idx) + EXTW'(NLANES)) <= EXTW'(vl);

    AST_REQ_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && lane_en == '0)); // R2
    AST_PAST_VL_OFF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && base_idx >= vl) |=> lane_en == '0); // R7
    AST_UNMASKED_FULL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !use_mask && sew_code <= SEW_CODE_W'(MAX_SEW_CODE) && group_fits)
        |=> lane_en == '1); // R6
    AST_BAD_SEW_OFF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sew_code > SEW_CODE_W'(MAX_SEW_CODE))
        |=> (out_valid && lane_en == '0)); // R8
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && use_mask && v0_bits == '0) |=> lane_en == '0); // R3
endmodule

// File: tb/vmask_extract_bench.sv
module vmask_extract_bench;
    localparam int VLEN   = 128;
    localparam int NLANES = 4;
    localparam int IDXW   = $clog2(VLEN) + 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [IDXW-1:0]   base_idx;
    logic [IDXW-1:0]   vl;
    logic [2:0]        sew_code;
    logic [1:0]        lmul_code;
    logic              use_mask;
    logic [VLEN-1:0]   v0_bits;
    logic              out_valid;
    logic [NLANES-1:0] lane_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    vmask_extract #(.VLEN(VLEN), .NLANES(NLANES), .IDXW(IDXW)) u_vmask_extract (
        .clk(clk), .rst(rst), .req_valid(req_valid), .base_idx(base_idx),
        .vl(vl), .sew_code(sew_code), .lmul_code(lmul_code),
        .use_mask(use_mask), .v0_bits(v0_bits),
        .out_valid(out_valid), .lane_en(lane_en)
    );

    function automatic logic [NLANES-1:0] model(int s, int l, int vlv, int base,
                                                bit um, logic [VLEN-1:0] v);
        logic [NLANES-1:0] r = '0;
        for (int k = 0; k < NLANES; k++) begin
            int idx = base + k;
            int mlen;
            int pos;
            if (s > 3 || idx >= vlv) r[k] = 1'b0;
            else if (!um) r[k] = 1'b1;
            else begin
                mlen = (8 << s) / (1 << l);
                pos  = idx * mlen;
                r[k] = (pos < VLEN) ? v[pos] : 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] next_rand(logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic compare(string tag, logic ev, logic [NLANES-1:0] ee);
        checks++;
        if (out_valid !== ev || lane_en !== ee) begin
            errors++;
            $display("FAIL %s: valid=%b en=%b expected valid=%b en=%b",
                     tag, out_valid, lane_en, ev, ee);
        end
    endtask

    // called at a negedge: drive, wait one edge, check at next negedge
    task automatic cycle(string tag, bit rq, int s, int l, int vlv, int base,
                         bit um, logic [VLEN-1:0] v);
        logic [NLANES-1:0] e;
        req_valid = rq; sew_code = 3'(s); lmul_code = 2'(l);
        vl = IDXW'(vlv); base_idx = IDXW'(base); use_mask = um; v0_bits = v;
        e = rq ? model(s, l, vlv, base, um, v) : '0;
        @(negedge clk);
        compare(tag, rq, e);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                errors++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [VLEN-1:0] pat;
        logic [NLANES-1:0] first_en;
        rst = 1'b1; req_valid = 1'b1; base_idx = '0; vl = IDXW'(8);
        sew_code = '0; lmul_code = '0; use_mask = 1'b0; v0_bits = '1;
        @(negedge clk); @(negedge clk);
        compare("R1 reset", 1'b0, '0);
        rst = 1'b0;

        // R2 idle cycle
        cycle("R2 idle", 0, 0, 0, 16, 0, 1, '1);
        // R3 SEW8 LMUL8 -> one-bit fields
        pat = 128'h0;
        pat[7:0] = 8'b1010_0101;
        cycle("R3 mlen1 base0", 1, 0, 3, 64, 0, 1, pat);
        cycle("R3 mlen1 base4", 1, 0, 3, 64, 4, 1, pat);
        // R3 SEW64 LMUL1 -> 64-bit fields
        pat = '0; pat[64] = 1'b1;
        cycle("R3 mlen64", 1, 3, 0, 2, 0, 1, pat);
        // R4 SEW32 LMUL2 -> 16-bit fields; upper field bits set, LSB only in field 1
        pat = {16'hFFFE, 16'hFFFE, 16'hFFFE, 16'hFFFE, 16'hFFFE, 16'hFFFE, 16'h0001, 16'hFFFE};
        cycle("R4 lsb only", 1, 2, 1, 8, 0, 1, pat);
        // R5 equal ratio: SEW16/LMUL2 and SEW8/LMUL1
        pat = 128'h0101_0001_0100_0101_0001_0000_0101_0100;
        cycle("R5 ratio a", 1, 1, 1, 16, 4, 1, pat);
        first_en = lane_en;
        cycle("R5 ratio b", 1, 0, 0, 16, 4, 1, pat);
        checks++;
        if (lane_en !== first_en) begin
            errors++;
            $display("FAIL R5 equal ratio: en=%b expected %b", lane_en, first_en);
        end
        // R6 unmasked with empty mask
        cycle("R6 unmasked", 1, 1, 0, 8, 0, 0, '0);
        // R7 vl boundary inside the group, both modes
        cycle("R7 vl cut unmasked", 1, 0, 0, 6, 4, 0, '1);
        cycle("R7 vl cut masked", 1, 0, 0, 2, 0, 1, '1);
        cycle("R7 vl zero", 1, 2, 2, 0, 0, 0, '1);
        // R8 illegal width codes
        cycle("R8 sew4", 1, 4, 0, 16, 0, 0, '1);
        cycle("R8 sew7", 1, 7, 3, 16, 0, 1, '1);
        // R9 field start beyond register
        cycle("R9 beyond", 1, 3, 0, 4, 0, 1, '1);
        cycle("R2 idle after", 0, 0, 0, 4, 0, 1, '1);

        // randomized stream within vl <= VLMAX
        for (int n = 0; n < 400; n++) begin
            int s, l, vmax, vlv, base;
            logic [VLEN-1:0] rv;
            lfsr = next_rand(lfsr);
            s = lfsr[1:0]; l = lfsr[3:2];
            vmax = (VLEN << l) / (8 << s);
            if (vmax > VLEN) vmax = VLEN;
            lfsr = next_rand(lfsr);
            vlv  = lfsr[15:0] % (vmax + 1);
            base = lfsr[31:16] % vmax;
            for (int w = 0; w < VLEN / 32; w++) begin
                lfsr = next_rand(lfsr);
                rv[w*32 +: 32] = lfsr;
            end
            cycle("R3 R6 R7 random", lfsr[5] | lfsr[6], s, l, vlv, base, lfsr[9], rv);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule